// File: doc/BRIEF.md
# NAND Bus Cycle Generator

This block turns a queue of cycle descriptors into NAND-style bus cycles on the controller side. Each descriptor holds a two-bit operation code and one byte. It becomes a command latch cycle, an address latch cycle, a data write cycle strobed by the active-low write strobe, or a data read cycle strobed by the active-low read strobe. Read bytes come back on a one-cycle valid pulse.

The block runs on `clk`, which is twice the controller clock. One controller period, tCK, is two `clk` cycles, and that lets the data strobes switch on half-tCK boundaries. Command and address cycles use whole-tCK setup, pulse and hold counts. These counts double when the extend input is high at the moment a descriptor leaves the queue. Data cycles always take one tCK. Descriptors are executed strictly in arrival order, and back-to-back descriptors follow each other without idle gaps.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, and whenever no descriptor is being executed, `nand_cle` and `nand_ale` are low, `nand_we_n` and `nand_re_n` are high, and `nand_io_oe` is low.
- R2: Op code 0 (command): `nand_cle` rises 2 clk cycles before `nand_we_n` falls. `nand_we_n` then stays low for 2 clk cycles. `nand_cle` stays high for 2 clk cycles after `nand_we_n` rises. `nand_ale` stays low throughout.
- R3: Op code 1 (address) follows the R2 timing on `nand_ale`, and `nand_cle` stays low throughout.
- R4: If the extend input is high when a command or address descriptor starts, the three intervals of R2 become 4, 4 and 4 clk cycles. This gives 4 tCK of latch setup to the strobe rise, 2 tCK of low pulse and 2 tCK of hold.
- R5: While `nand_cle` or `nand_ale` is high, `nand_io_oe` is high and `nand_io_out` carries the descriptor byte without change.
- R6: Op code 2 (data write) drives `nand_we_n` low for exactly 1 clk cycle and then high for 1 clk cycle. The byte is on `nand_io_out` with `nand_io_oe` high while the strobe is low. The extend input has no effect on this timing. Consecutive writes have a write strobe fall every 2 clk cycles.
- R7: Op code 3 (data read) drives `nand_re_n` low for exactly 1 clk cycle with `nand_io_oe` low. `nand_io_in` is sampled on the clock edge where `nand_re_n` returns high. In the cycle that follows, `rd_valid` is high for one cycle and `rd_data` holds the sampled byte.
- R8: Once a descriptor has started, a change on the extend input does not alter that descriptor's cycle.
- R9: Up to DEPTH descriptors wait in the queue behind the one being executed. `desc_ready` is low while the queue is full. Descriptors leave the queue in arrival order.
- R10: `nand_cle` and `nand_ale` are never high together, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the controller clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Extended command/address timing, sampled when a descriptor starts |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Queue has room |
| desc_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| desc_byte | input | 8 | Byte for command, address or write |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus value driven by the controller |
| nand_io_oe | output | 1 | Bus drive enable |
| nand_io_in | input | 8 | Bus value from the flash |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Captured read byte |

## Verification
A wrong sequencer state or count shows up at once on the latch and strobe pins. The interval between a latch rise, the strobe fall and the strobe rise moves by whole clk cycles, and that is visible within a single descriptor of at most 12 cycles. A stale extend register or a wrong sampling point shows up as a 6-versus-12-cycle latch window. A queue pointer fault shows up as bytes in the wrong order, or as a missing back-pressure, within one burst of descriptors. A wrong capture point shows up on the first read as the wrong byte, or as a valid pulse that does not follow the read strobe rise.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CA_PRE,
    S_CA_LOW,
    S_CA_HOLD,
    S_DW_LOW,
    S_DW_HIGH,
    S_DR_LOW,
    S_DR_HIGH
  } seq_e;

  typedef struct packed {
    op_e              op;
    logic [BUS_W-1:0] data;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/nfc_desc_fifo.sv
module nfc_desc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign empty   = (fill == '0);
  assign full    = (fill == (AW+1)'(DEPTH));
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/nfc_cycle_seq.sv
module nfc_cycle_seq
  import nfc_pkg::*;
#(
  parameter int PRE_TCK  = 1,
  parameter int LOW_TCK  = 1,
  parameter int HOLD_TCK = 1,
  parameter int EXT_MULT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic             head_valid,
  input  desc_t            head,
  output logic             pop,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [BUS_W-1:0] io_out,
  output logic             io_oe,
  output logic             cap_en
);
  localparam int MAXD = 2 * (PRE_TCK + LOW_TCK + HOLD_TCK) * EXT_MULT;
  localparam int CW   = $clog2(MAXD + 1);

  seq_e             state, nxt;
  logic [CW-1:0]    cnt, nxt_cnt;
  logic             ext_q, nxt_ext;
  op_e              op_q, nxt_op;
  logic [BUS_W-1:0] byte_q, nxt_byte;
  logic             last;

  // interval length in clk cycles, minus one, for a count given in tCK
  function automatic logic [CW-1:0] span(input int tck, input logic ext);
    int v;
    v = 2 * tck * (ext ? EXT_MULT : 1);
    return CW'(v - 1);
  endfunction

  always_comb begin
    nxt      = state;
    nxt_cnt  = cnt;
    nxt_ext  = ext_q;
    nxt_op   = op_q;
    nxt_byte = byte_q;
    pop      = 1'b0;
    last     = (state == S_IDLE) || (state == S_DW_HIGH) || (state == S_DR_HIGH) ||
               ((state == S_CA_HOLD) && (cnt == '0));
    if (last && head_valid) begin
      pop      = 1'b1;
      nxt_op   = head.op;
      nxt_byte = head.data;
      nxt_ext  = ext_mode;
      case (head.op)
        OP_CMD, OP_ADDR: begin
          nxt     = S_CA_PRE;
          nxt_cnt = span(PRE_TCK, ext_mode);
        end
        OP_WDATA: nxt = S_DW_LOW;
        default:  nxt = S_DR_LOW;
      endcase
    end else begin
      case (state)
        S_CA_PRE: begin
          if (cnt == '0) begin
            nxt     = S_CA_LOW;
            nxt_cnt = span(LOW_TCK, ext_q);
          end else nxt_cnt = cnt - 1'b1;
        end
        S_CA_LOW: begin
          if (cnt == '0) begin
            nxt     = S_CA_HOLD;
            nxt_cnt = span(HOLD_TCK, ext_q);
          end else nxt_cnt = cnt - 1'b1;
        end
        S_CA_HOLD: begin
          if (cnt == '0) nxt = S_IDLE;
          else nxt_cnt = cnt - 1'b1;
        end
        S_DW_LOW: nxt = S_DW_HIGH;
        S_DR_LOW: nxt = S_DR_HIGH;
        default:  nxt = S_IDLE;
      endcase
    end
  end

  logic is_ca_n, drive_n;
  assign is_ca_n = (nxt == S_CA_PRE) || (nxt == S_CA_LOW) || (nxt == S_CA_HOLD);
  assign drive_n = is_ca_n || (nxt == S_DW_LOW) || (nxt == S_DW_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      ext_q  <= 1'b0;
      op_q   <= OP_CMD;
      byte_q <= '0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      io_oe  <= 1'b0;
      io_out <= '0;
    end else begin
      state  <= nxt;
      cnt    <= nxt_cnt;
      ext_q  <= nxt_ext;
      op_q   <= nxt_op;
      byte_q <= nxt_byte;
      cle    <= is_ca_n && (nxt_op == OP_CMD);
      ale    <= is_ca_n && (nxt_op == OP_ADDR);
      we_n   <= !((nxt == S_CA_LOW) || (nxt == S_DW_LOW));
      re_n   <= !(nxt == S_DR_LOW);
      io_oe  <= drive_n;
      io_out <= drive_n ? nxt_byte : '0;
    end
  end

  assign cap_en = (state == S_DR_LOW);
endmodule

// File: rtl/nfc_rd_capture.sv
module nfc_rd_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] io_in,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= io_in;
    end
  end
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nfc_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int PRE_TCK  = 1,
  parameter int LOW_TCK  = 1,
  parameter int HOLD_TCK = 1,
  parameter int EXT_MULT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [1:0]       desc_op,
  input  logic [BUS_W-1:0] desc_byte,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [BUS_W-1:0] nand_io_out,
  output logic             nand_io_oe,
  input  logic [BUS_W-1:0] nand_io_in,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_data
);
  logic [DESC_W-1:0] q_rdata;
  logic              q_empty, q_full, q_pop, cap_en;
  desc_t             head;

  assign desc_ready = !q_full;
  assign head       = desc_t'(q_rdata);

  nfc_desc_fifo #(.DEPTH(DEPTH), .W(DESC_W)) u_queue (
    .clk   (clk),
    .rst   (rst),
    .push  (desc_valid),
    .wdata ({desc_op, desc_byte}),
    .pop   (q_pop),
    .rdata (q_rdata),
    .empty (q_empty),
    .full  (q_full)
  );

  nfc_cycle_seq #(
    .PRE_TCK (PRE_TCK),
    .LOW_TCK (LOW_TCK),
    .HOLD_TCK(HOLD_TCK),
    .EXT_MULT(EXT_MULT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ext_mode  (ext_mode),
    .head_valid(!q_empty),
    .head      (head),
    .pop       (q_pop),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .io_out    (nand_io_out),
    .io_oe     (nand_io_oe),
    .cap_en    (cap_en)
  );

  nfc_rd_capture #(.W(BUS_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .io_in   (nand_io_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cle,
  input logic         ale,
  input logic         we_n,
  input logic         re_n,
  input logic [W-1:0] io_out,
  input logic         io_oe,
  input logic         rd_valid
);
  p_excl_latch_r10: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  p_excl_strobe_r10: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  p_read_released_r7: assert property (@(posedge clk) disable iff (rst) !re_n |-> !io_oe);
  p_rd_after_rise_r7: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $rose(re_n));
  p_wdata_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(we_n) && !cle && !ale) |=> we_n);
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(we_n) && $past(cle || ale)) |-> (cle || ale));
  p_ca_bus_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!we_n && (cle || ale)) |-> ($stable(io_out) && io_oe));
  p_we_drives_r6: assert property (@(posedge clk) disable iff (rst) !we_n |-> io_oe);
endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(.W(nfc_pkg::BUS_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cle     (nand_cle),
  .ale     (nand_ale),
  .we_n    (nand_we_n),
  .re_n    (nand_re_n),
  .io_out  (nand_io_out),
  .io_oe   (nand_io_oe),
  .rd_valid(rd_valid)
);

// File: tb/nand_cycle_gen_tb.sv
module nand_cycle_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_mode = 1'b0;
  logic       desc_valid = 1'b0;
  logic       desc_ready;
  logic [1:0] desc_op = 2'd0;
  logic [7:0] desc_byte = 8'h00;
  logic       nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, rd_valid;
  logic [7:0] nand_io_out, rd_data;
  logic [7:0] nand_io_in = 8'h00;

  int nchecks = 0;
  int nerrors = 0;

  always #4 clk = ~clk;

  nand_cycle_gen u_dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_op(desc_op), .desc_byte(desc_byte),
    .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic       ext;
    logic [7:0] rd_in;
    logic [4:0] pre;
    logic [4:0] low;
    logic [4:0] hold;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h70, 1'b0, 8'h00, 5'd2, 5'd2, 5'd2},
    '{2'd1, 8'h15, 1'b0, 8'h00, 5'd2, 5'd2, 5'd2},
    '{2'd0, 8'hFF, 1'b1, 8'h00, 5'd4, 5'd4, 5'd4},
    '{2'd1, 8'hA5, 1'b1, 8'h00, 5'd4, 5'd4, 5'd4},
    '{2'd2, 8'h3C, 1'b0, 8'h00, 5'd0, 5'd1, 5'd0},
    '{2'd2, 8'hC3, 1'b1, 8'h00, 5'd0, 5'd1, 5'd0},
    '{2'd3, 8'h00, 1'b0, 8'h5A, 5'd0, 5'd1, 5'd0},
    '{2'd3, 8'h00, 1'b1, 8'hA6, 5'd0, 5'd1, 5'd0}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    int lvl;
    lvl = {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe};
    check(lvl == 5'b00110, tag, lvl, 5'b00110);
  endtask

  task automatic run_vec(input vec_t v);
    int lat = 0, pre = 0, wel = 0, rel = 0, rdn = 0, iobad = 0, clen = 0, alen = 0;
    logic seen_we = 1'b0;
    int rdd = 0;
    string tg;
    @(negedge clk);
    ext_mode = v.ext; nand_io_in = v.rd_in;
    desc_valid = 1'b1; desc_op = v.op; desc_byte = v.data;
    @(negedge clk);
    desc_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (nand_cle || nand_ale) begin
        lat++;
        if (!seen_we && nand_we_n) pre++;
        if (nand_io_out != v.data || !nand_io_oe) iobad++;
      end
      if (!nand_we_n) begin
        wel++; seen_we = 1'b1;
        if (v.op == 2'd2 && (nand_io_out != v.data || !nand_io_oe)) iobad++;
      end
      if (!nand_re_n) begin
        rel++;
        if (nand_io_oe) iobad++;
      end
      if (rd_valid) begin rdn++; rdd = int'(rd_data); end
      clen += int'(nand_cle);
      alen += int'(nand_ale);
    end
    if (v.op <= 2'd1) begin
      tg = v.ext ? "R4 ext" : (v.op == 2'd0 ? "R2 cmd" : "R3 addr");
      check(pre == int'(v.pre), {tg, " latch before strobe"}, pre, int'(v.pre));
      check(wel == int'(v.low), {tg, " strobe low"}, wel, int'(v.low));
      check(lat - pre - wel == int'(v.hold), {tg, " latch hold"}, lat - pre - wel, int'(v.hold));
      check(iobad == 0, "R5 bus byte during latch", iobad, 0);
      if (v.op == 2'd0) check(alen == 0, "R2 ale quiet", alen, 0);
      else check(clen == 0, "R3 cle quiet", clen, 0);
    end else if (v.op == 2'd2) begin
      check(wel == 1, "R6 write strobe low", wel, 1);
      check(lat == 0 && rel == 0, "R6 no latch or read", lat + rel, 0);
      check(iobad == 0, "R6 write byte", iobad, 0);
    end else begin
      check(rel == 1, "R7 read strobe low", rel, 1);
      check(rdn == 1, "R7 one valid pulse", rdn, 1);
      check(rdd == int'(v.rd_in), "R7 read byte", rdd, int'(v.rd_in));
      check(iobad == 0 && wel == 0, "R7 bus released", iobad + wel, 0);
    end
    check_idle("R1 idle after descriptor");
  endtask

  task automatic run_ext_flip(input logic start_ext, input int exp_lat);
    int lat = 0;
    fork
      begin
        @(negedge clk);
        ext_mode = start_ext; desc_valid = 1'b1; desc_op = 2'd0; desc_byte = 8'h90;
        @(negedge clk);
        desc_valid = 1'b0;
        repeat (2) @(negedge clk);
        ext_mode = !start_ext;
      end
      begin
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          if (nand_cle) lat++;
        end
      end
    join
    check(lat == exp_lat, "R8 extend held for started cycle", lat, exp_lat);
  endtask

  task automatic run_burst_writes();
    int falls = 0, gap_bad = 0, last_t = -1, byte_bad = 0;
    logic prev_we = 1'b1;
    ext_mode = 1'b1;
    fork
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          desc_valid = 1'b1; desc_op = 2'd2; desc_byte = 8'h40 + 8'(k);
        end
        @(negedge clk);
        desc_valid = 1'b0;
      end
      begin
        for (int t = 0; t < 20; t++) begin
          @(negedge clk);
          if (!nand_we_n && prev_we) begin
            if (last_t >= 0 && t - last_t != 2) gap_bad++;
            if (nand_io_out != 8'h40 + 8'(falls)) byte_bad++;
            last_t = t;
            falls++;
          end
          prev_we = nand_we_n;
        end
      end
    join
    check(falls == 3, "R6 burst write count", falls, 3);
    check(gap_bad == 0, "R6 one tCK per write", gap_bad, 0);
    check(byte_bad == 0, "R6 burst bytes", byte_bad, 0);
  endtask

  task automatic run_queue_fill();
    int got = 0, order_bad = 0;
    logic saw_full = 1'b0;
    logic prev_we = 1'b1;
    ext_mode = 1'b1;
    fork
      begin
        for (int k = 0; k < 7; k++) begin
          @(negedge clk);
          while (!desc_ready) begin
            saw_full = 1'b1; desc_valid = 1'b0;
            @(negedge clk);
          end
          desc_valid = 1'b1; desc_op = 2'd0; desc_byte = 8'h10 + 8'(k);
        end
        @(negedge clk);
        desc_valid = 1'b0;
      end
      begin
        for (int t = 0; t < 150; t++) begin
          @(negedge clk);
          if (!nand_we_n && prev_we) begin
            if (nand_io_out != 8'h10 + 8'(got)) order_bad++;
            got++;
          end
          prev_we = nand_we_n;
        end
      end
    join
    check(saw_full, "R9 ready low when queue full", int'(saw_full), 1);
    check(got == 7, "R9 all descriptors issued", got, 7);
    check(order_bad == 0, "R9 arrival order", order_bad, 0);
  endtask

  initial begin
    #(8 * 100000);
    nerrors++;
    nchecks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 reset levels");
    check(desc_ready == 1'b1, "R9 ready after reset", int'(desc_ready), 1);
    check(rd_valid == 1'b0, "R1 no read valid after reset", int'(rd_valid), 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    run_ext_flip(1'b0, 6);
    run_ext_flip(1'b1, 12);
    run_burst_writes();
    run_queue_fill();
    repeat (5) @(negedge clk);
    check_idle("R1 idle at end");
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  end
endmodule